// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block turns a master audio clock into the two timing clocks an audio serial link needs: a bit clock running at one half or one quarter of the master rate, and a frame (word-select) clock that toggles after a fixed number of bit clock periods. The frame clock is cascaded from the bit clock, so a full frame is 32, 64 or 128 bit clock periods, split into two equal halves. The whole block runs in the master clock domain: both outputs are registers that change only on master clock edges.

A single 32-bit control word, written and read back over a plain register port, sets the run enable, the frame clock edge relationship and the divide choices. An override bit decides where the divide choices come from. When it is set, they come from the control word. When it is clear, they come from selection inputs driven by the neighbouring serial port block. Settings are held in an active copy that changes only while the generator is idle or at a frame boundary, so a running frame is never cut short. There is no streaming data path, so all pins are plain control and clock signals.

Top module: `audio_frame_clkgen`

## Requirements
- R1: After reset, `sclk` and `lrclk` are low and `cfg_rdata` reads 0.
- R2: A write stores only bits 31, 29, 19, 18:17 and 16 of `cfg_wdata`. All other bits read back as 0, so writing all ones reads back 0xA00F0000.
- R3: With the effective bit clock select at 0, each `sclk` level lasts 1 master cycle (divide by 2). With it at 1, each level lasts 2 master cycles (divide by 4).
- R4: The effective frame select codes 00, 01 and 10 give 16, 32 and 64 `sclk` periods per `lrclk` half (divide by 32, 64, 128). The high and low halves are equal.
- R5: With the effective frame select at 11, `lrclk` stays low while `sclk` keeps running.
- R6: Bit 31 enables both outputs. When it is cleared, both outputs go low at the next `sclk` half-period boundary and stay low.
- R7: With bit 19 at 1, every `lrclk` transition coincides with a falling `sclk` edge. With bit 19 at 0, it coincides with a rising `sclk` edge.
- R8: With bit 29 at 1, bits 16 and 18:17 of the register choose the divides. With bit 29 at 0, `port_sdiv4` and `port_lrsel` choose them, using the same encodings, and the register's divide bits have no effect. Enable and polarity always come from the register.
- R9: After enable, `sclk` starts low and `lrclk` is low for the first half-frame. That half-frame ends on the selected-type `sclk` edge numbered by the R4 count.
- R10: A change to the divide or polarity settings while running takes effect at the next falling `lrclk` transition. The frame in progress finishes with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Stored control word |
| port_sdiv4 | input | 1 | Bit clock select from the serial port, used when override is clear |
| port_lrsel | input | 2 | Frame select from the serial port, used when override is clear |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |

## Verification
The assertions assume that `port_sdiv4` and `port_lrsel` are synchronous to `mclk`. They also assume that polarity is read only from the active copy of the settings, so an edge-type check never mixes an old polarity with a new one. The stimulus changes the port selects only while the generator is disabled. Every run-time setting change is a register write, which lands on a master clock edge and is therefore seen consistently by both counters.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int REG_W    = 32;
  localparam int BIT_EN   = 31;
  localparam int BIT_OVR  = 29;
  localparam int BIT_POL  = 19;
  localparam int BIT_LR0  = 17;
  localparam int BIT_SDIV = 16;
  localparam logic [REG_W-1:0] WMASK =
      (32'd1 << BIT_EN) | (32'd1 << BIT_OVR) | (32'd1 << BIT_POL) |
      (32'd3 << BIT_LR0) | (32'd1 << BIT_SDIV);

  typedef enum logic [1:0] {
    LR_X32  = 2'b00,
    LR_X64  = 2'b01,
    LR_X128 = 2'b10,
    LR_BAD  = 2'b11
  } lr_sel_e;

  typedef struct packed {
    logic    sdiv4;
    lr_sel_e lrsel;
    logic    pol;
  } afc_cfg_t;
endpackage

// File: rtl/afc_ctrl_regs.sv
module afc_ctrl_regs
  import afc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             port_sdiv4,
  input  logic [1:0]       port_lrsel,
  output logic [REG_W-1:0] rdata,
  output logic             en,
  output afc_cfg_t         cfg
);
  logic [REG_W-1:0] word_q;
  logic             ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (wr) word_q <= wdata & WMASK;
  end

  always_comb begin
    ovr       = word_q[BIT_OVR];
    rdata     = word_q;
    en        = word_q[BIT_EN];
    cfg.sdiv4 = ovr ? word_q[BIT_SDIV] : port_sdiv4;
    cfg.lrsel = lr_sel_e'(ovr ? word_q[BIT_LR0 +: 2] : port_lrsel);
    cfg.pol   = word_q[BIT_POL];
  end

  assert_rdback_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata == ($past(wdata) & WMASK));
endmodule

// File: rtl/afc_bitclk_gen.sv
module afc_bitclk_gen #(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic stop,
  output logic sclk,
  output logic tick
);
  localparam int PC_W = $clog2(SLOW_HALF + 1);

  logic [PC_W-1:0] pc, lim;

  always_comb begin
    lim  = slow ? PC_W'(SLOW_HALF - 1) : PC_W'(FAST_HALF - 1);
    tick = run && (pc == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      pc   <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      pc   <= '0;
      sclk <= stop ? 1'b0 : ~sclk;
    end else begin
      pc   <= pc + 1'b1;
    end
  end

  assert_hold_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(sclk));
endmodule

// File: rtl/afc_frame_gen.sv
module afc_frame_gen
  import afc_pkg::*;
#(
  parameter int BASE_HALF = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    step,
  input  logic    stop,
  input  lr_sel_e lrsel,
  output logic    lrclk,
  output logic    frame_end
);
  localparam int BC_W = $clog2(BASE_HALF * 4);

  logic [BC_W-1:0] bc, lim;
  logic            bad, wrap;

  always_comb begin
    case (lrsel)
      LR_X64:  lim = BC_W'(2 * BASE_HALF - 1);
      LR_X128: lim = BC_W'(4 * BASE_HALF - 1);
      default: lim = BC_W'(BASE_HALF - 1);
    endcase
    bad       = (lrsel == LR_BAD);
    wrap      = step && (bc == lim);
    frame_end = wrap && (lrclk || bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc    <= '0;
      lrclk <= 1'b0;
    end else if (!run || stop) begin
      bc    <= '0;
      lrclk <= 1'b0;
    end else if (step) begin
      if (wrap) begin
        bc    <= '0;
        lrclk <= bad ? 1'b0 : ~lrclk;
      end else begin
        bc <= bc + 1'b1;
      end
    end
  end

  assert_bad_code_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lrsel == LR_BAD) |-> !lrclk);
endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
  import afc_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 2,
  parameter int BASE_HALF = 16
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             port_sdiv4,
  input  logic [1:0]       port_lrsel,
  output logic             sclk,
  output logic             lrclk
);
  afc_cfg_t cfg_sel, cfg_act;
  logic     en, run_q, tick, stop, step, frame_end;

  afc_ctrl_regs u_regs (
    .clk        (mclk),
    .rst_n      (rst_n),
    .wr         (cfg_wr),
    .wdata      (cfg_wdata),
    .port_sdiv4 (port_sdiv4),
    .port_lrsel (port_lrsel),
    .rdata      (cfg_rdata),
    .en         (en),
    .cfg        (cfg_sel)
  );

  always_comb begin
    stop = run_q && tick && !en;
    step = tick && !stop && (cfg_act.pol ? sclk : !sclk);
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cfg_act <= '0;
    end else begin
      if (!run_q)    run_q <= en;
      else if (stop) run_q <= 1'b0;
      if (!run_q || frame_end) cfg_act <= cfg_sel;
    end
  end

  afc_bitclk_gen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_bit (
    .clk   (mclk),
    .rst_n (rst_n),
    .run   (run_q),
    .slow  (cfg_act.sdiv4),
    .stop  (stop),
    .sclk  (sclk),
    .tick  (tick)
  );

  afc_frame_gen #(.BASE_HALF(BASE_HALF)) u_frame (
    .clk       (mclk),
    .rst_n     (rst_n),
    .run       (run_q),
    .step      (step),
    .stop      (stop),
    .lrsel     (cfg_act.lrsel),
    .lrclk     (lrclk),
    .frame_end (frame_end)
  );

  assert_idle_low_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    !run_q |-> (!sclk && !lrclk));
  assert_start_phase_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(run_q) |-> (!sclk && !lrclk));
  assert_rise_edge_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    ($rose(lrclk) && !cfg_act.pol) |-> $rose(sclk));
  assert_fall_edge_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    ($rose(lrclk) && cfg_act.pol) |-> $fell(sclk));
  assert_frame_only_R10: assert property (@(posedge mclk) disable iff (!rst_n)
    (run_q && !frame_end) |=> $stable(cfg_act));
endmodule

// File: tb/tb_audio_frame_clkgen.sv
`timescale 1ns/1ps
module tb_audio_frame_clkgen;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        port_sdiv4 = 1'b0;
  logic [1:0]  port_lrsel = 2'b00;
  logic        sclk, lrclk;

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] OVR = 32'h2000_0000;
  localparam logic [31:0] POL = 32'h0008_0000;
  localparam logic [31:0] SD4 = 32'h0001_0000;

  typedef struct { int h; int k; bit pol; string tag; } exp_t;
  exp_t expq[$];
  bit   item_done = 1'b0;
  int   total = 0, bad = 0;

  audio_frame_clkgen dut (
    .mclk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .port_sdiv4(port_sdiv4), .port_lrsel(port_lrsel),
    .sclk(sclk), .lrclk(lrclk));

  always #4 clk = ~clk;

  function automatic logic [31:0] lrf(int c);
    return 32'(c) << 17;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Runs until lrclk changes; counts sclk rises and level-length errors.
  task automatic half_len(input int h, output int rises, output int badh,
                          output logic sclk_at);
    logic pl, ps;
    int   cnt;
    bit   seen;
    pl = lrclk; ps = sclk; cnt = 0; seen = 0; rises = 0; badh = 0; sclk_at = 1'b0;
    forever begin
      @(negedge clk);
      cfg_wr = 1'b0;
      if (sclk != ps) begin
        if (sclk) rises++;
        if (seen && cnt != h) badh++;
        seen = 1; cnt = 1;
      end else cnt++;
      ps = sclk;
      if (lrclk != pl) begin
        sclk_at = sclk;
        break;
      end
    end
  endtask

  // Monitor: pops expected items and measures the running clocks.
  initial begin
    forever begin
      exp_t e;
      int r0, r1, r2, b0, b1, b2;
      logic s0, s1, s2;
      wait (expq.size() > 0);
      e = expq.pop_front();
      half_len(e.h, r0, b0, s0);
      half_len(e.h, r1, b1, s1);
      half_len(e.h, r2, b2, s2);
      chk(r0 == e.k, "R9", {e.tag, " first low half sclk periods"}, r0, e.k);
      chk(r1 == e.k, "R4", {e.tag, " high half sclk periods"}, r1, e.k);
      chk(r2 == e.k, "R4", {e.tag, " low half sclk periods"}, r2, e.k);
      chk(b0 + b1 + b2 == 0, "R3", {e.tag, " sclk level length errors"}, b0 + b1 + b2, 0);
      chk(s0 == !e.pol && s1 == !e.pol && s2 == !e.pol, "R7",
          {e.tag, " sclk level at lrclk edges"}, {s0, s1, s2}, e.pol ? 0 : 7);
      item_done = 1'b1;
    end
  end

  task automatic stop_and_check(string tag);
    int hits;
    wr_reg(32'h0);
    repeat (4) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || lrclk) hits++;
    end
    chk(hits == 0, "R6", {tag, " samples with output high after disable"}, hits, 0);
  endtask

  task automatic run_case(logic [31:0] v, int h, int k, bit pol, string tag);
    exp_t e;
    item_done = 1'b0;
    wr_reg(v);
    e.h = h; e.k = k; e.pol = pol; e.tag = tag;
    expq.push_back(e);
    wait (item_done);
    stop_and_check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, rs, r1, r2, r3, b;
    logic s;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 0, "R1", "sclk after reset", sclk, 0);
    chk(lrclk == 0, "R1", "lrclk after reset", lrclk, 0);
    chk(cfg_rdata == 0, "R1", "readback after reset", cfg_rdata, 0);

    // R2 mask and R5 unsupported frame code (all ones: enabled, override, code 11)
    wr_reg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'hA00F_0000, "R2", "masked readback", cfg_rdata, 32'hA00F_0000);
    hi = 0; rs = 0; prev = sclk;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (lrclk) hi++;
      if (sclk && !prev) rs++;
      prev = sclk;
    end
    chk(hi == 0, "R5", "lrclk high samples with code 11", hi, 0);
    chk(rs == 75, "R5", "sclk rises with code 11 divide by 4", rs, 75);
    stop_and_check("R5 stop");

    run_case(EN | OVR | lrf(0), 1, 16, 0, "R3 R4 div2 x32 rise");
    run_case(EN | OVR | SD4 | lrf(1) | POL, 2, 32, 1, "R3 R4 div4 x64 fall");
    run_case(EN | OVR | lrf(2) | POL, 1, 64, 1, "R4 div2 x128 fall");
    // R8: override clear, register divide fields ignored, port selects used
    port_sdiv4 = 1'b0; port_lrsel = 2'b00;
    run_case(EN | SD4 | lrf(2), 1, 16, 0, "R8 port div2 x32");
    port_sdiv4 = 1'b1; port_lrsel = 2'b01;
    run_case(EN, 2, 32, 0, "R8 port div4 x64");
    port_sdiv4 = 1'b0; port_lrsel = 2'b00;

    // R10: change frame divide mid-frame, applied at the next falling lrclk
    wr_reg(EN | OVR | lrf(0));
    half_len(1, r1, b, s);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = EN | OVR | lrf(1);
    half_len(1, r1, b, s);
    half_len(1, r2, b, s);
    half_len(1, r3, b, s);
    chk(r1 == 16, "R10", "high half keeps old divide", r1, 16);
    chk(r2 == 32, "R10", "low half after boundary uses new divide", r2, 32);
    chk(r3 == 32, "R10", "next high half uses new divide", r3, 32);
    stop_and_check("R10 stop");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule